// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings up to two SDRAM modules out of power-up. A one-cycle start pulse launches a fixed command series: NOP, precharge-all, eight CBR refreshes and a mode-register set. Each is followed by a programmed wait. The series ends with a switch of the controller into normal mode, after which `done` rises. Every command except the final mode change goes out on a valid/ready issue port as a 3-bit command code plus a byte address. One transfer is made for each populated module side.

Target addresses come from a packed population code that holds four bits per slot. Each code gives a slot size and a first-side bank size in MB. Slots are laid out back to back from address zero in slot order. A second transfer is made into a slot only when its bank size is nonzero. For the mode-register set, the address also carries an offset that depends on the slot index and on the requested CAS latency. The population code and CAS selection are captured at start. Waits are counted in clock cycles, derived from a clocks-per-microsecond parameter. A wait begins only once the last transfer of a command has been accepted.

Top module: `sdinit_seq`

## Requirements
- R1: After start, transfers are offered in this order: NOP, precharge-all, eight CBR refreshes, mode-register set. The command codes are self-refresh 0, normal 1, normal-fast 2, NOP 4, precharge-all 5, mode-register set 6 and CBR 7.
- R2: Each wait begins when the last target of a command has been handled. The waits in microseconds are 200 after NOP, 1 after precharge, 1 after each CBR, 2 after the mode-register set and 1 after the switch to normal. Each microsecond is CLK_PER_US cycles. Nothing is offered during a wait.
- R3: The normal command is never offered on the issue port. `ctrl_mode` is 0 after reset, equals the command being issued during the series, and is 1 once the series ends.
- R4: While `iss_valid` is high and `iss_ready` is low, `iss_cmd` and `iss_addr` hold their values. Backpressure only delays the series and never alters it.
- R5: The population code of slot i sits in `pop_code[4i+3:4i]`. Codes 0 to F map to slot sizes in MB of 0,8,0,16,16,24,32,32,48,64,64,96,128,128,192,256, and to first-side bank sizes in MB of 0,0,0,8,0,16,16,0,32,32,0,64,64,0,128,128. Code 2 is therefore an empty slot.
- R6: Each command visits slot 0 then slot 1. A slot's base is the sum of the sizes of the slots before it. A slot with a nonzero size receives base×2^20+offset. A slot with a nonzero bank size also receives (base+bank)×2^20+offset.
- R7: For the mode-register set, the offset is 0x1D0 for slot 0 and 0x650 for slot 1 when `cas3`=1, and 0x150 for slot 0 and 0x1A0 for slot 1 when `cas3`=0. Every other command uses offset 0.
- R8: `pop_code` and `cas3` are taken at the accepted start. A start pulse, or a change of these inputs, while the series runs has no effect on the transfers.
- R9: `done` is low from reset and during the series. It rises after the final wait, stays high, and drops when the next start is accepted, which reruns the series.
- R10: In reset, `iss_valid`, `done` and `ctrl_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle or done |
| cas3 | input | 1 | CAS latency select, 1 = CAS 3, 0 = CAS 2 |
| pop_code | input | 8 | Per-slot population codes |
| iss_valid | output | 1 | Command transfer offered |
| iss_ready | input | 1 | Command transfer accepted |
| iss_cmd | output | 3 | Command code |
| iss_addr | output | ADDR_W (32) | Byte address of the target side |
| ctrl_mode | output | 3 | Current controller command mode |
| done | output | 1 | Series complete, normal mode active |

## Verification
The series runs under several population mixes: one single-sided module, one double-sided module in slot 1 only, a double-sided module with a single-sided one, two double-sided modules, two single-sided modules, a reserved code beside an odd-size module, and no modules at all. Each mix tests a different path. The empty-slot-0 and reserved-code cases show whether the base chain and side skipping are right. The mixed cases show whether the bank offset is applied to the correct slot. The two CAS settings show that the mode-register offset depends on both slot and latency. The same mixes are run with a stalling `iss_ready` and with a start pulse in the middle carrying inverted inputs, which tests the hold and capture rules. A reset in the middle of a run and the NOP wait length cover the remaining timing.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    localparam int SD_SLOTS = 2;
    localparam int TGT_W    = $clog2(2 * SD_SLOTS);
    localparam int MB_W     = $clog2(256 * SD_SLOTS + 1);
    localparam int MB_SHIFT = 20;

    typedef enum logic [2:0] {
        CMD_SELFREF   = 3'd0,
        CMD_NORMAL    = 3'd1,
        CMD_NORM_FAST = 3'd2,
        CMD_NOP       = 3'd4,
        CMD_PRECHARGE = 3'd5,
        CMD_MODESET   = 3'd6,
        CMD_CBR       = 3'd7
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_NOP, PH_PRE, PH_CBR, PH_MRS, PH_NORM
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic            ok;
        logic [MB_W-1:0] mb;
    } side_t;

    function automatic logic [8:0] slot_mb(input logic [3:0] code);
        case (code)
            4'h1: return 9'd8;
            4'h3, 4'h4: return 9'd16;
            4'h5: return 9'd24;
            4'h6, 4'h7: return 9'd32;
            4'h8: return 9'd48;
            4'h9, 4'hA: return 9'd64;
            4'hB: return 9'd96;
            4'hC, 4'hD: return 9'd128;
            4'hE: return 9'd192;
            4'hF: return 9'd256;
            default: return 9'd0;
        endcase
    endfunction

    function automatic logic [7:0] bank_mb(input logic [3:0] code);
        case (code)
            4'h3: return 8'd8;
            4'h5, 4'h6: return 8'd16;
            4'h8, 4'h9: return 8'd32;
            4'hB, 4'hC: return 8'd64;
            4'hE, 4'hF: return 8'd128;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [10:0] mrs_offset(input int slot, input logic cas3);
        if (slot == 0) return cas3 ? 11'h1D0 : 11'h150;
        if (slot == 1) return cas3 ? 11'h650 : 11'h1A0;
        return 11'h000;
    endfunction

endpackage

// File: rtl/sdinit_targets.sv
module sdinit_targets
    import sdinit_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [4*SD_SLOTS-1:0] pop,
    input  sd_cmd_e               cmd,
    input  logic                  cas3,
    input  logic [TGT_W-1:0]      tgt,
    output logic                  tgt_ok,
    output logic [ADDR_W-1:0]     tgt_addr
);
    logic [MB_W-1:0] sz   [SD_SLOTS];
    logic [MB_W-1:0] bk   [SD_SLOTS];
    logic [MB_W-1:0] base [SD_SLOTS+1];

    assign base[0] = '0;

    for (genvar s = 0; s < SD_SLOTS; s++) begin : g_slot
        assign sz[s]     = MB_W'(slot_mb(pop[4*s +: 4]));
        assign bk[s]     = MB_W'(bank_mb(pop[4*s +: 4]));
        assign base[s+1] = base[s] + sz[s];
    end

    logic [TGT_W-2:0] sl;
    logic [10:0]      off;
    side_t            side;

    always_comb begin
        sl  = tgt[TGT_W-1:1];
        off = (cmd == CMD_MODESET) ? mrs_offset(int'(sl), cas3) : 11'h000;
        if (!tgt[0]) begin
            side.ok = (sz[sl] != '0);
            side.mb = base[sl];
        end else begin
            side.ok = (bk[sl] != '0);
            side.mb = base[sl] + bk[sl];
        end
        tgt_ok   = side.ok;
        tgt_addr = (ADDR_W'(side.mb) << MB_SHIFT) + ADDR_W'(off);
    end

endmodule

// File: rtl/sdinit_wait.sv
module sdinit_wait #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             fire
);
    logic             running;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= load_val - 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign fire = running && (cnt == '0);

    // R2: a running wait moves down by exactly one per cycle
    a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
        (running && cnt != '0 && !load) |=> (running && cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CLK_PER_US = 100,
    parameter int NOP_US     = 200,
    parameter int PRE_US     = 1,
    parameter int CBR_US     = 1,
    parameter int MRS_US     = 2,
    parameter int NORM_US    = 1,
    parameter int REF_N      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  cas3,
    input  logic [4*SD_SLOTS-1:0] pop_code,
    output logic                  iss_valid,
    input  logic                  iss_ready,
    output logic [2:0]            iss_cmd,
    output logic [ADDR_W-1:0]     iss_addr,
    output logic [2:0]            ctrl_mode,
    output logic                  done
);
    localparam int DLY_NOP  = NOP_US  * CLK_PER_US;
    localparam int DLY_PRE  = PRE_US  * CLK_PER_US;
    localparam int DLY_CBR  = CBR_US  * CLK_PER_US;
    localparam int DLY_MRS  = MRS_US  * CLK_PER_US;
    localparam int DLY_NORM = NORM_US * CLK_PER_US;
    localparam int M1 = (DLY_NOP > DLY_PRE) ? DLY_NOP : DLY_PRE;
    localparam int M2 = (DLY_CBR > DLY_MRS) ? DLY_CBR : DLY_MRS;
    localparam int M3 = (M1 > M2) ? M1 : M2;
    localparam int DLY_MAX = (M3 > DLY_NORM) ? M3 : DLY_NORM;
    localparam int CNT_W = $clog2(DLY_MAX + 1);
    localparam int REF_W = $clog2(REF_N + 1);
    localparam logic [TGT_W-1:0] TGT_LAST = TGT_W'(2 * SD_SLOTS - 1);

    seq_st_e               st_q;
    phase_e                ph_q;
    sd_cmd_e               mode_q;
    logic [REF_W-1:0]      ref_q;
    logic [TGT_W-1:0]      tgt_q;
    logic                  cas_q;
    logic [4*SD_SLOTS-1:0] pop_q;

    logic              tgt_ok;
    logic [ADDR_W-1:0] tgt_addr;
    logic              arm;
    logic [CNT_W-1:0]  arm_val;
    logic              fire;
    logic              step;

    sdinit_targets #(.ADDR_W(ADDR_W)) u_tgt (
        .pop      (pop_q),
        .cmd      (mode_q),
        .cas3     (cas_q),
        .tgt      (tgt_q),
        .tgt_ok   (tgt_ok),
        .tgt_addr (tgt_addr)
    );

    sdinit_wait #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (arm),
        .load_val (arm_val),
        .fire     (fire)
    );

    // a target is finished when accepted, or skipped when the side is absent
    assign step = (st_q == ST_ISSUE) && (!tgt_ok || iss_ready);

    always_comb begin
        arm     = 1'b0;
        arm_val = CNT_W'(DLY_NORM);
        if (step && tgt_q == TGT_LAST) begin
            arm = 1'b1;
            case (ph_q)
                PH_NOP:  arm_val = CNT_W'(DLY_NOP);
                PH_PRE:  arm_val = CNT_W'(DLY_PRE);
                PH_CBR:  arm_val = CNT_W'(DLY_CBR);
                default: arm_val = CNT_W'(DLY_MRS);
            endcase
        end else if (st_q == ST_WAIT && fire && ph_q == PH_MRS) begin
            arm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ph_q   <= PH_NOP;
            mode_q <= CMD_SELFREF;
            ref_q  <= '0;
            tgt_q  <= '0;
            cas_q  <= 1'b0;
            pop_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE, ST_DONE: if (start) begin
                    st_q   <= ST_ISSUE;
                    ph_q   <= PH_NOP;
                    mode_q <= CMD_NOP;
                    ref_q  <= '0;
                    tgt_q  <= '0;
                    cas_q  <= cas3;
                    pop_q  <= pop_code;
                end
                ST_ISSUE: if (step) begin
                    if (tgt_q == TGT_LAST) st_q  <= ST_WAIT;
                    else                   tgt_q <= tgt_q + 1'b1;
                end
                ST_WAIT: if (fire) begin
                    tgt_q <= '0;
                    case (ph_q)
                        PH_NOP: begin
                            ph_q <= PH_PRE; mode_q <= CMD_PRECHARGE; st_q <= ST_ISSUE;
                        end
                        PH_PRE: begin
                            ph_q <= PH_CBR; mode_q <= CMD_CBR; st_q <= ST_ISSUE;
                        end
                        PH_CBR: begin
                            st_q <= ST_ISSUE;
                            if (ref_q == REF_W'(REF_N - 1)) begin
                                ph_q <= PH_MRS; mode_q <= CMD_MODESET;
                            end else begin
                                ref_q <= ref_q + 1'b1;
                            end
                        end
                        PH_MRS: begin
                            ph_q <= PH_NORM; mode_q <= CMD_NORMAL;
                        end
                        default: st_q <= ST_DONE;
                    endcase
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign iss_valid = (st_q == ST_ISSUE) && tgt_ok;
    assign iss_cmd   = mode_q;
    assign iss_addr  = tgt_addr;
    assign ctrl_mode = mode_q;
    assign done      = (st_q == ST_DONE);

    // R4: an offered transfer holds until taken
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_cmd) && $stable(iss_addr)));

    // R3: the normal mode change never reaches the issue port
    a_r3_no_normal: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (iss_cmd != CMD_NORMAL));

    // R9: finished sequencer offers nothing
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !iss_valid);

    // R7: commands other than mode-register set land on MB boundaries
    a_r7_plain_offset: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_cmd != CMD_MODESET) |-> (iss_addr[MB_SHIFT-1:0] == '0));

    // R9: done holds until a start is seen
    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

endmodule

// File: tb/sim_sdinit_seq.sv
module sim_sdinit_seq;
    localparam int CPU = 2;
    localparam int AW  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cas3 = 1'b0;
    logic [7:0]    pop_code = 8'h00;
    logic          iss_valid;
    logic          iss_ready = 1'b1;
    logic [2:0]    iss_cmd;
    logic [AW-1:0] iss_addr;
    logic [2:0]    ctrl_mode;
    logic          done;

    sdinit_seq #(.ADDR_W(AW), .CLK_PER_US(CPU)) u0 (
        .clk(clk), .rst(rst), .start(start), .cas3(cas3), .pop_code(pop_code),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cmd(iss_cmd),
        .iss_addr(iss_addr), .ctrl_mode(ctrl_mode), .done(done)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic stall = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) begin
        #1 iss_ready = stall ? ((cyc % 3) != 2) : 1'b1;
    end

    logic [2:0]    exp_cmd  [64];
    logic [AW-1:0] exp_addr [64];
    int            exp_n;
    logic [2:0]    act_cmd  [64];
    logic [AW-1:0] act_addr [64];
    int            act_cyc  [64];
    int            act_n = 0;

    always @(negedge clk) begin
        if (!rst && iss_valid && iss_ready) begin
            if (act_n < 64) begin
                act_cmd[act_n]  = iss_cmd;
                act_addr[act_n] = iss_addr;
                act_cyc[act_n]  = cyc;
            end
            act_n = act_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int tb_size(input logic [3:0] c);
        int t [16] = '{0,8,0,16,16,24,32,32,48,64,64,96,128,128,192,256};
        return t[c];
    endfunction
    function automatic int tb_bank(input logic [3:0] c);
        int t [16] = '{0,0,0,8,0,16,16,0,32,32,0,64,64,0,128,128};
        return t[c];
    endfunction

    task automatic build(input logic [7:0] pop, input logic cas);
        exp_n = 0;
        for (int k = 0; k < 11; k++) begin
            logic [2:0] c;
            int base;
            c = (k == 0) ? 3'd4 : (k == 1) ? 3'd5 : (k == 10) ? 3'd6 : 3'd7;
            base = 0;
            for (int s = 0; s < 2; s++) begin
                int sz, bk, off;
                sz = tb_size(pop[4*s +: 4]);
                bk = tb_bank(pop[4*s +: 4]);
                off = 0;
                if (c == 3'd6) off = (s == 0) ? (cas ? 'h1D0 : 'h150) : (cas ? 'h650 : 'h1A0);
                if (sz != 0) begin
                    exp_cmd[exp_n] = c; exp_addr[exp_n] = AW'(base * 1048576 + off); exp_n++;
                end
                if (bk != 0) begin
                    exp_cmd[exp_n] = c; exp_addr[exp_n] = AW'((base + bk) * 1048576 + off); exp_n++;
                end
                base += sz;
            end
        end
    endtask

    task automatic pulse_start(input logic [7:0] pop, input logic cas);
        @(posedge clk); #1 pop_code = pop; cas3 = cas; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done, "R9", "watchdog done", {31'd0, done}, 32'd1);
    endtask

    // {stall, cas3, pop_code}
    localparam logic [9:0] VEC [7] = '{
        {1'b0, 1'b1, 8'h0D},   // slot0 single-sided
        {1'b0, 1'b1, 8'hC0},   // slot1 only, double-sided
        {1'b1, 1'b0, 8'hDC},   // double + single, stalled
        {1'b1, 1'b1, 8'hFF},   // two double-sided, stalled
        {1'b0, 1'b0, 8'h25},   // reserved code in slot1, odd size slot0
        {1'b0, 1'b1, 8'h00},   // empty
        {1'b0, 1'b0, 8'hDD}    // two single-sided
    };

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!iss_valid, "R10", "reset valid", {31'd0, iss_valid}, 0);
        chk(!done, "R10", "reset done", {31'd0, done}, 0);
        chk(ctrl_mode == 3'd0, "R10", "reset mode", {29'd0, ctrl_mode}, 0);
        @(posedge clk); #1 rst = 1'b0;

        for (int v = 0; v < 7; v++) begin
            logic [7:0] pop;
            logic cas;
            int nops;
            pop = VEC[v][7:0]; cas = VEC[v][8]; stall = VEC[v][9];
            build(pop, cas);
            act_n = 0;
            pulse_start(pop, cas);
            @(negedge clk);
            chk(!done, "R9", "done low in run", {31'd0, done}, 0);
            chk(ctrl_mode == 3'd4, "R3", "mode during NOP", {29'd0, ctrl_mode}, 4);
            repeat (50) @(posedge clk);
            pulse_start(~pop, ~cas);      // R8: ignored while busy
            pop_code = pop; cas3 = cas;
            wait_done();
            chk(act_n == exp_n, "R1", "transfer count", act_n, exp_n);
            for (int i = 0; i < exp_n && i < act_n; i++) begin
                chk(act_cmd[i] == exp_cmd[i], "R1", "command", {29'd0, act_cmd[i]}, {29'd0, exp_cmd[i]});
                chk(act_addr[i] == exp_addr[i], (exp_cmd[i] == 3'd6) ? "R7" : "R6",
                    "address", act_addr[i], exp_addr[i]);
            end
            chk(ctrl_mode == 3'd1, "R3", "mode after series", {29'd0, ctrl_mode}, 1);
            nops = 0;
            for (int i = 0; i < exp_n; i++) if (exp_cmd[i] == 3'd4) nops++;
            if (!stall && nops > 0 && act_n > nops) begin
                int gap;
                gap = act_cyc[nops] - act_cyc[nops-1];
                chk(gap >= 200*CPU + 1 && gap <= 200*CPU + 6, "R2", "NOP wait", gap, 200*CPU + 1);
            end
            repeat (20) @(negedge clk);
            chk(done && !iss_valid, "R9", "done holds", {31'd0, done}, 1);
        end

        // R2: empty population still walks all waits before done
        stall = 1'b0;
        act_n = 0;
        pulse_start(8'h00, 1'b0);
        begin
            int n = 0;
            while (!done && n < 5000) begin @(negedge clk); n++; end
            chk(n >= (200 + 1 + 8 + 2 + 1) * CPU, "R2", "empty run length", n, (212) * CPU);
        end
        chk(act_n == 0, "R5", "empty issues nothing", act_n, 0);

        // R10: reset in the middle of a run
        pulse_start(8'hFF, 1'b1);
        repeat (30) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!iss_valid && !done && ctrl_mode == 3'd0, "R10", "mid-run reset",
            {28'd0, iss_valid, ctrl_mode}, 0);
        @(posedge clk); #1 rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule